// File: doc/BRIEF.md
# Conditional Branch Resolver and Next-PC Selector

This block decides whether a conditional branch instruction in a single-cycle core redirects the program counter, and it drives the PC register's next value. All four supported comparisons are resolved from the result of one ALU subtraction of the two source registers, A−B. The zero flag of that subtraction settles equality and inequality. The most significant bit of the difference settles signed less-than and greater-or-equal. The three-bit function field of the instruction chooses which of these tests applies.

The block is purely combinational and holds no state. The branch-enable bit from the main decoder gates the decision. For any instruction that is not a conditional branch, the selector passes the incremented PC through. The branch target is computed elsewhere and arrives as an input. Unsigned comparisons and jumps are handled outside this block. The ordering test reads the raw sign bit of the difference, so signed overflow of A−B is not corrected.

Top module: `branch_next_pc`

## Requirements
- R1: With the branch enable high and funct3 = 3'b000 (equal), next_pc equals target when alu_zero is 1 and equals pc_plus4 when alu_zero is 0.
- R2: With the branch enable high and funct3 = 3'b001 (not equal), next_pc equals target when alu_zero is 0 and equals pc_plus4 when alu_zero is 1.
- R3: With the branch enable high and funct3 = 3'b100 (less than), next_pc equals target when alu_sign is 1 and equals pc_plus4 when alu_sign is 0. alu_zero has no effect on this result.
- R4: With the branch enable high and funct3 = 3'b101 (greater or equal), next_pc equals target when alu_sign is 0 and equals pc_plus4 when alu_sign is 1. alu_zero has no effect on this result.
- R5: For operands A and B whose difference does not overflow, feeding the zero flag and sign bit of A−B makes the four branch kinds follow A==B, A!=B, A<B and A>=B as signed comparisons.
- R6: With the branch enable high and any funct3 other than 000, 001, 100 or 101, next_pc equals pc_plus4 whatever the flags.
- R7: With the branch enable low, next_pc equals pc_plus4 for every funct3 and flag value.
- R8: next_pc is always exactly one of pc_plus4 or target, bit for bit, and follows its inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| br_en | input | 1 | Conditional-branch enable from the main decoder |
| funct3 | input | 3 | Function field of the instruction; selects the comparison |
| alu_zero | input | 1 | Set when the ALU subtraction A−B is zero |
| alu_sign | input | 1 | Most significant bit of the ALU subtraction A−B |
| pc_plus4 | input | 32 | Sequential next address |
| target | input | 32 | Computed branch destination |
| next_pc | output | 32 | Value to load into the PC |

## Verification
The hardest case to reach is an ordering branch whose sign bit disagrees with the zero flag in a way that arithmetic cannot produce. Another hard case is a sign bit that means something because it comes from real operands rather than from free flags. The bench therefore runs two sweeps. The first walks every combination of enable, funct3, zero flag and sign bit, including combinations no subtraction can give. The second subtracts every pair of small signed operands in the range −8..7, where overflow is impossible, and derives the flags from that subtraction. Expected results come from the signed comparison itself. The two address inputs are always distinct, so any wrong selection shows at the output.

// File: rtl/branch_pkg.sv
package branch_pkg;

   localparam int unsigned F3_W = 3;

   typedef enum logic [F3_W-1:0] {
      CMP_EQ  = 3'b000,
      CMP_NE  = 3'b001,
      CMP_LT  = 3'b100,
      CMP_GE  = 3'b101
   } cmp_kind_e;

   // Selector implementation variants
   localparam int unsigned MUX_TERNARY = 0;
   localparam int unsigned MUX_ANDOR   = 1;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
   import branch_pkg::*;
(
   input  logic [F3_W-1:0] funct3,
   input  logic            alu_zero,
   input  logic            alu_sign,
   output logic            cond_true
);

   always_comb begin
      case (funct3)
         CMP_EQ:  cond_true = alu_zero;
         CMP_NE:  cond_true = ~alu_zero;
         CMP_LT:  cond_true = alu_sign;
         CMP_GE:  cond_true = ~alu_sign;
         default: cond_true = 1'b0;
      endcase
   end

endmodule

// File: rtl/brc_gate.sv
module brc_gate (
   input  logic br_en,
   input  logic cond_true,
   output logic take
);

   assign take = br_en & cond_true;

endmodule

// File: rtl/brc_pc_mux.sv
module brc_pc_mux
   import branch_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned MUX_STYLE = MUX_ANDOR
) (
   input  logic            take,
   input  logic [XLEN-1:0] seq_pc,
   input  logic [XLEN-1:0] jmp_pc,
   output logic [XLEN-1:0] sel_pc
);

   generate
      if (MUX_STYLE == MUX_TERNARY) begin : g_tern
         assign sel_pc = take ? jmp_pc : seq_pc;
      end else if (MUX_STYLE == MUX_ANDOR) begin : g_andor
         logic [XLEN-1:0] mask;
         assign mask   = {XLEN{take}};
         assign sel_pc = (jmp_pc & mask) | (seq_pc & ~mask);
      end else begin : g_bad
         $error("brc_pc_mux: unsupported MUX_STYLE %0d", MUX_STYLE);
      end
   endgenerate

endmodule

// File: rtl/branch_next_pc.sv
module branch_next_pc
   import branch_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned MUX_STYLE = MUX_ANDOR
) (
   input  logic            br_en,
   input  logic [2:0]      funct3,
   input  logic            alu_zero,
   input  logic            alu_sign,
   input  logic [XLEN-1:0] pc_plus4,
   input  logic [XLEN-1:0] target,
   output logic [XLEN-1:0] next_pc
);

   localparam int unsigned ALIGN_BITS = 2;

   generate
      if (XLEN <= ALIGN_BITS) begin : g_xlen_bad
         $error("branch_next_pc: XLEN %0d too small", XLEN);
      end
   endgenerate

   logic cond_true;
   logic take;

   brc_cond_eval u_cond (
      .funct3    (funct3),
      .alu_zero  (alu_zero),
      .alu_sign  (alu_sign),
      .cond_true (cond_true)
   );

   brc_gate u_gate (
      .br_en     (br_en),
      .cond_true (cond_true),
      .take      (take)
   );

   brc_pc_mux #(
      .XLEN      (XLEN),
      .MUX_STYLE (MUX_STYLE)
   ) u_mux (
      .take   (take),
      .seq_pc (pc_plus4),
      .jmp_pc (target),
      .sel_pc (next_pc)
   );

endmodule

// File: rtl/branch_next_pc_chk.sv
module branch_next_pc_chk #(
   parameter int unsigned XLEN = 32
) (
   input logic            br_en,
   input logic [2:0]      funct3,
   input logic            alu_zero,
   input logic            alu_sign,
   input logic [XLEN-1:0] pc_plus4,
   input logic [XLEN-1:0] target,
   input logic [XLEN-1:0] next_pc
);

   always_comb begin
      if (br_en && funct3 == 3'b000) begin
         // R1
         eq_sel_chk: assert (next_pc == (alu_zero ? target : pc_plus4));
      end
      if (br_en && funct3 == 3'b001) begin
         // R2
         ne_sel_chk: assert (next_pc == (alu_zero ? pc_plus4 : target));
      end
      if (br_en && funct3 == 3'b100) begin
         // R3
         lt_sel_chk: assert (next_pc == (alu_sign ? target : pc_plus4));
      end
      if (br_en && funct3 == 3'b101) begin
         // R4
         ge_sel_chk: assert (next_pc == (alu_sign ? pc_plus4 : target));
      end
      if (br_en && funct3 != 3'b000 && funct3 != 3'b001 &&
          funct3 != 3'b100 && funct3 != 3'b101) begin
         // R6
         unknown_f3_chk: assert (next_pc == pc_plus4);
      end
      if (!br_en) begin
         // R7
         no_branch_chk: assert (next_pc == pc_plus4);
      end
      // R8
      one_of_two_chk: assert (next_pc == pc_plus4 || next_pc == target);
   end

endmodule

bind branch_next_pc branch_next_pc_chk #(.XLEN(XLEN)) u_chk (
   .br_en    (br_en),
   .funct3   (funct3),
   .alu_zero (alu_zero),
   .alu_sign (alu_sign),
   .pc_plus4 (pc_plus4),
   .target   (target),
   .next_pc  (next_pc)
);

// File: tb/tb_branch_next_pc.sv
`timescale 1ns/1ps
module tb_branch_next_pc;

   localparam int unsigned XLEN = 32;

   logic            clk = 1'b0;
   logic            br_en;
   logic [2:0]      funct3;
   logic            alu_zero;
   logic            alu_sign;
   logic [XLEN-1:0] pc_plus4;
   logic [XLEN-1:0] target;
   logic [XLEN-1:0] next_pc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   branch_next_pc #(.XLEN(XLEN)) dut (
      .br_en    (br_en),
      .funct3   (funct3),
      .alu_zero (alu_zero),
      .alu_sign (alu_sign),
      .pc_plus4 (pc_plus4),
      .target   (target),
      .next_pc  (next_pc)
   );

   task automatic check(input string req, input logic [XLEN-1:0] exp);
      checks++;
      if (next_pc !== exp) begin
         errors++;
         $display("FAIL %s: br_en=%0b f3=%03b z=%0b s=%0b got %h exp %h",
                  req, br_en, funct3, alu_zero, alu_sign, next_pc, exp);
      end
   endtask

   // drive on falling edge, sample mid-low phase
   task automatic apply(input logic en, input logic [2:0] f3, input logic z,
                        input logic s, input logic [XLEN-1:0] p4,
                        input logic [XLEN-1:0] tg);
      @(negedge clk);
      br_en = en; funct3 = f3; alu_zero = z; alu_sign = s;
      pc_plus4 = p4; target = tg;
      #2;
   endtask

   function automatic string req_of(input logic en, input logic [2:0] f3);
      if (!en) return "R7";
      case (f3)
         3'b000:  return "R1";
         3'b001:  return "R2";
         3'b100:  return "R3";
         3'b101:  return "R4";
         default: return "R6";
      endcase
   endfunction

   initial begin
      br_en = 0; funct3 = 0; alu_zero = 0; alu_sign = 0;
      pc_plus4 = 0; target = 0;

      // initial state: disabled, distinct addresses -> sequential (R7)
      apply(1'b0, 3'b000, 1'b1, 1'b0, 32'h0000_1004, 32'h0000_2000);
      check("R7 initial", 32'h0000_1004);

      // Sweep 1: every enable/funct3/flag combination, several address pairs
      for (int pi = 0; pi < 3; pi++) begin
         logic [XLEN-1:0] p4, tg;
         p4 = 32'h0000_0104 + 32'(pi) * 32'h0001_0000;
         tg = ~p4 ^ 32'(pi);
         for (int e = 0; e < 2; e++)
            for (int f = 0; f < 8; f++)
               for (int zz = 0; zz < 2; zz++)
                  for (int ss = 0; ss < 2; ss++) begin
                     bit tk;
                     tk = 1'b0;
                     if (e == 1) begin
                        case (f)
                           0: tk = (zz == 1);
                           1: tk = (zz == 0);
                           4: tk = (ss == 1);
                           5: tk = (ss == 0);
                           default: tk = 1'b0;
                        endcase
                     end
                     apply(e[0], f[2:0], zz[0], ss[0], p4, tg);
                     check(req_of(e[0], f[2:0]), tk ? tg : p4);
                  end
      end

      // Sweep 2: flags from a real signed subtraction, no overflow (R5)
      for (int a = -8; a < 8; a++)
         for (int b = -8; b < 8; b++) begin
            logic [XLEN-1:0] diff;
            diff = 32'(a) - 32'(b);
            for (int k = 0; k < 4; k++) begin
               logic [2:0] f3;
               bit tk;
               case (k)
                  0: begin f3 = 3'b000; tk = (a == b); end
                  1: begin f3 = 3'b001; tk = (a != b); end
                  2: begin f3 = 3'b100; tk = (a <  b); end
                  default: begin f3 = 3'b101; tk = (a >= b); end
               endcase
               apply(1'b1, f3, diff == 0, diff[XLEN-1],
                     32'h0040_0010 + 32'(a + 8), 32'h0080_0000 + 32'(b + 8));
               check("R5", tk ? 32'h0080_0000 + 32'(b + 8)
                              : 32'h0040_0010 + 32'(a + 8));
            end
         end

      // R8: no clock needed; output follows a mid-phase input change
      @(negedge clk);
      br_en = 1; funct3 = 3'b000; alu_zero = 1; alu_sign = 0;
      pc_plus4 = 32'hAAAA_0004; target = 32'h5555_0000;
      #1;
      check("R8 comb", 32'h5555_0000);
      alu_zero = 0;
      #1;
      check("R8 comb", 32'hAAAA_0004);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete (got hang, exp finish)");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule